// File: doc/BRIEF.md
# Code Store Lock and Verify Controller

This block guards a 4K-byte on-chip code store in an 8-bit microcontroller. Three one-time lock fuses set the protection. Each programmed fuse adds to what the ones before it already block. The block decides three things: whether a table read (MOVC) may return internal code, whether the production verify port may read code back, and whether execution from external memory is allowed. The fuses cannot be read directly. Their state can only be seen through the protections that are active.

MOVC reads come in on a valid/ready request stream. They leave on a valid/ready response stream that carries the byte and a denial flag. The request side is ready only when the response slot is empty or is being drained in the same cycle, so the block never holds more than one response. While the response is stalled it holds its data and flag unchanged. The verify port is plain pin-level control. It is qualified by the reset pin and a fixed pattern on the strobe, latch, access and select pins. A two-bit key chooses between code bytes and three fixed identification bytes.

The external-access strap is normally used live. Once the first fuse is programmed, the effective strap is the value captured while the reset pin was last high. Before any such capture it reads 0.

Top module: `codelock_ctrl`

## Requirements
- R1: After `rst_n` deasserts, `rsp_valid` and `vfy_oe` are 0 and `vfy_data` is 00h. With fuse 0 programmed and no reset-pin pulse yet, `ea_eff` is 0 whatever `ea_pin` is.
- R2: With no fuse programmed, `prog_en` and `ext_exec_en` are 1. `ea_eff` follows `ea_pin` in the same cycle. MOVC reads are granted whether `req_from_ext` is 0 or 1.
- R3: With fuse 0 (`lock_prog[0]`) programmed, `prog_en` is 0. An accepted request with `req_from_ext`=1 yields `rsp_denied`=1 and `rsp_data`=00h. An accepted request with `req_from_ext`=0 is still granted.
- R4: With fuse 0 programmed, `ea_eff` equals the `ea_pin` value sampled on the last clock edge at which `rst_pin` was high. Later changes of `ea_pin` have no effect on it.
- R5: The verify code read is selected by `rst_pin`=1, `vfy_strobe_n`=0, `vfy_ale`=1, `ea_pin`=1, `vfy_bank_sel`=0 and `vfy_key`=2'b11. With `vfy_out_en_n`=0 and fuses 0 and 1 unprogrammed, `vfy_oe`=1 and `vfy_data` holds the byte at `vfy_addr` one clock edge later. The byte at address a is a[7:0] ^ {a[11:8],a[11:8]} ^ A5h.
- R6: When fuse 0 or fuse 1 is programmed, a verify code read leaves `vfy_oe`=0 and `vfy_data`=00h.
- R7: The signature read uses the selection of R5 with `vfy_key`=2'b00. It returns 1Eh at 030h, 80h at 031h, 01h at 032h and FFh at any other address, whatever the fuses are.
- R8: If `vfy_out_en_n` is 1, or any selection pin differs from R5/R7 (including `vfy_key` 01 or 10), `vfy_oe` is 0 and `vfy_data` is 00h one edge later.
- R9: `ext_exec_en` is 0 only when all three fuses are programmed. With fuses 0 and 1 only, it stays 1.
- R10: `req_ready` = !`rst_pin` and (!`rsp_valid` or `rsp_ready`). A request accepted on an edge gives `rsp_valid`=1 after that edge. While `rsp_valid`=1 and `rsp_ready`=0, `rsp_data` and `rsp_denied` stay stable.
- R11: A clock edge with `rst_pin`=1 discards any pending response (`rsp_valid`=0 after it).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low flop reset |
| lock_prog | input | 3 | Fuse states, 1 = programmed, bit 0 is the first fuse |
| rst_pin | input | 1 | Hardware reset pin level (active high) |
| ea_pin | input | 1 | External-access strap, 1 = internal execution |
| prog_en | output | 1 | Further programming permitted |
| ext_exec_en | output | 1 | Execution from external memory permitted |
| ea_eff | output | 1 | Effective strap value |
| req_valid | input | 1 | MOVC request valid |
| req_ready | output | 1 | MOVC request accepted when high with valid |
| req_addr | input | 12 | MOVC code address |
| req_from_ext | input | 1 | Requesting instruction was fetched externally |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_data | output | 8 | Response byte (00h when denied) |
| rsp_denied | output | 1 | Request was refused by the lock |
| vfy_strobe_n | input | 1 | Verify read strobe, active low |
| vfy_ale | input | 1 | Verify latch pin, must be high |
| vfy_bank_sel | input | 1 | Verify select pin, must be low |
| vfy_out_en_n | input | 1 | Verify output enable, active low |
| vfy_key | input | 2 | 11 = code read, 00 = signature read |
| vfy_addr | input | 12 | Verify address |
| vfy_data | output | 8 | Verify data |
| vfy_oe | output | 1 | Verify data drive enable |

## Verification
The assertions assume that lock fuses only change while `rst_n` is low or between scenarios, never while a request is in flight. They also assume that verify selection and MOVC traffic never overlap: verify needs `rst_pin` high, and that same level forces `req_ready` low. The bench drives all inputs on the falling edge, changes fuses only while the request stream is idle, and raises the reset pin only when no new request is offered. The strap property also relies on `ea_eff` being checked only after at least one cycle with `rst_pin` low under a steady fuse 0.

// File: rtl/codelock_pkg.sv
package codelock_pkg;
  localparam int CL_AW = 12;
  localparam int CL_DW = 8;
  localparam int CL_NLOCK = 3;

  typedef enum logic [1:0] {
    VKEY_SIG  = 2'b00,
    VKEY_CODE = 2'b11
  } vfy_key_e;

  typedef struct packed {
    logic movc_ext_block;
    logic strap_hold;
    logic prog_block;
    logic vfy_block;
    logic ext_block;
  } lock_pol_t;

  function automatic logic [CL_DW-1:0] pattern_byte(input logic [CL_AW-1:0] a,
                                                    input logic [CL_DW-1:0] seed);
    logic [CL_DW-1:0] hi;
    hi = {a[11:8], a[11:8]};
    return a[7:0] ^ hi ^ seed;
  endfunction

  function automatic logic [CL_DW-1:0] sig_byte(input logic [CL_AW-1:0] a);
    case (a)
      12'h030: return 8'h1E;
      12'h031: return 8'h80;
      12'h032: return 8'h01;
      default: return 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/codelock_policy.sv
module codelock_policy
  import codelock_pkg::*;
#(
  parameter int NLOCK = CL_NLOCK
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NLOCK-1:0] lock_prog,
  input  logic             rst_pin,
  input  logic             ea_pin,
  output lock_pol_t        pol,
  output logic             ea_eff
);
  logic [NLOCK-1:0] lock_run;
  logic             ea_cap_q;

  assign lock_run[0] = lock_prog[0];
  for (genvar i = 1; i < NLOCK; i++) begin : g_run
    assign lock_run[i] = lock_run[i-1] & lock_prog[i];
  end

  always_comb begin
    pol.movc_ext_block = lock_prog[0];
    pol.strap_hold     = lock_prog[0];
    pol.prog_block     = lock_prog[0];
    pol.vfy_block      = lock_prog[0] | lock_prog[1];
    pol.ext_block      = lock_run[NLOCK-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ea_cap_q <= 1'b0;
    else if (rst_pin) ea_cap_q <= ea_pin;
  end

  assign ea_eff = pol.strap_hold ? ea_cap_q : ea_pin;

  // R4
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_pin && !$past(rst_pin) && lock_prog[0] && $past(lock_prog[0])) |-> $stable(ea_eff));
endmodule

// File: rtl/codelock_rom.sv
module codelock_rom
  import codelock_pkg::*;
#(
  parameter int AW = CL_AW,
  parameter int DW = CL_DW,
  parameter logic [DW-1:0] SEED = 8'hA5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= pattern_byte(addr, SEED);
  end
endmodule

// File: rtl/codelock_verify.sv
module codelock_verify
  import codelock_pkg::*;
#(
  parameter int AW = CL_AW,
  parameter int DW = CL_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rst_pin,
  input  logic          ea_pin,
  input  logic          strobe_n,
  input  logic          ale,
  input  logic          bank_sel,
  input  logic          out_en_n,
  input  logic [1:0]    key,
  input  logic [AW-1:0] addr,
  input  logic          vfy_block,
  input  logic [DW-1:0] rom_q,
  output logic          code_rd,
  output logic [DW-1:0] vfy_data,
  output logic          vfy_oe
);
  logic          base_sel, sig_rd;
  logic          oe_q, sig_q;
  logic [DW-1:0] sigb_q;

  assign base_sel = rst_pin & ~strobe_n & ale & ea_pin & ~bank_sel;
  assign code_rd  = base_sel & (key == VKEY_CODE);
  assign sig_rd   = base_sel & (key == VKEY_SIG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q   <= 1'b0;
      sig_q  <= 1'b0;
      sigb_q <= '0;
    end else begin
      oe_q   <= ~out_en_n & ((code_rd & ~vfy_block) | sig_rd);
      sig_q  <= sig_rd;
      sigb_q <= sig_byte(addr);
    end
  end

  assign vfy_oe   = oe_q;
  assign vfy_data = oe_q ? (sig_q ? sigb_q : rom_q) : '0;

  // R6
  vfy_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(vfy_block) && $past(key) == VKEY_CODE) |-> !vfy_oe);
  // R8
  vfy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(out_en_n) || !$past(rst_pin)) |-> (!vfy_oe && vfy_data == '0));
endmodule

// File: rtl/codelock_ctrl.sv
module codelock_ctrl
  import codelock_pkg::*;
#(
  parameter int AW = CL_AW,
  parameter int DW = CL_DW,
  parameter int NLOCK = CL_NLOCK,
  parameter logic [DW-1:0] SEED = 8'hA5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NLOCK-1:0] lock_prog,
  input  logic             rst_pin,
  input  logic             ea_pin,
  output logic             prog_en,
  output logic             ext_exec_en,
  output logic             ea_eff,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    req_addr,
  input  logic             req_from_ext,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [DW-1:0]    rsp_data,
  output logic             rsp_denied,
  input  logic             vfy_strobe_n,
  input  logic             vfy_ale,
  input  logic             vfy_bank_sel,
  input  logic             vfy_out_en_n,
  input  logic [1:0]       vfy_key,
  input  logic [AW-1:0]    vfy_addr,
  output logic [DW-1:0]    vfy_data,
  output logic             vfy_oe
);
  lock_pol_t     pol;
  logic          code_rd, accept, deny, rom_en;
  logic [AW-1:0] rom_addr;
  logic [DW-1:0] rom_q;
  logic          rsp_valid_q, rsp_denied_q;

  codelock_policy #(.NLOCK(NLOCK)) policy_i (
    .clk(clk), .rst_n(rst_n), .lock_prog(lock_prog), .rst_pin(rst_pin),
    .ea_pin(ea_pin), .pol(pol), .ea_eff(ea_eff)
  );

  codelock_verify #(.AW(AW), .DW(DW)) verify_i (
    .clk(clk), .rst_n(rst_n), .rst_pin(rst_pin), .ea_pin(ea_pin),
    .strobe_n(vfy_strobe_n), .ale(vfy_ale), .bank_sel(vfy_bank_sel),
    .out_en_n(vfy_out_en_n), .key(vfy_key), .addr(vfy_addr),
    .vfy_block(pol.vfy_block), .rom_q(rom_q), .code_rd(code_rd),
    .vfy_data(vfy_data), .vfy_oe(vfy_oe)
  );

  assign req_ready = ~rst_pin & (~rsp_valid_q | rsp_ready);
  assign accept    = req_valid & req_ready;
  assign deny      = pol.movc_ext_block & req_from_ext;
  assign rom_en    = code_rd | (accept & ~deny);
  assign rom_addr  = code_rd ? vfy_addr : req_addr;

  codelock_rom #(.AW(AW), .DW(DW), .SEED(SEED)) rom_i (
    .clk(clk), .rst_n(rst_n), .en(rom_en), .addr(rom_addr), .q(rom_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q  <= 1'b0;
      rsp_denied_q <= 1'b0;
    end else if (rst_pin) begin
      rsp_valid_q  <= 1'b0;
    end else if (accept) begin
      rsp_valid_q  <= 1'b1;
      rsp_denied_q <= deny;
    end else if (rsp_ready) begin
      rsp_valid_q  <= 1'b0;
    end
  end

  assign rsp_valid   = rsp_valid_q;
  assign rsp_denied  = rsp_denied_q;
  assign rsp_data    = (rsp_valid_q & ~rsp_denied_q) ? rom_q : '0;
  assign prog_en     = ~pol.prog_block;
  assign ext_exec_en = ~pol.ext_block;

  // R3
  movc_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && lock_prog[0] && req_from_ext) |=> (rsp_valid && rsp_denied && rsp_data == '0));
  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready && !rst_pin) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_denied)));
  // R10
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
  // R11
  rst_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_pin) |-> !rsp_valid);
endmodule

// File: tb/codelock_ctrl_tb_top.sv
module codelock_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  lock_prog = 3'b001;
  logic        rst_pin = 1'b0, ea_pin = 1'b1;
  logic        prog_en, ext_exec_en, ea_eff;
  logic        req_valid = 1'b0, req_ready, req_from_ext = 1'b0;
  logic [11:0] req_addr = '0;
  logic        rsp_valid, rsp_ready = 1'b1, rsp_denied;
  logic [7:0]  rsp_data;
  logic        vfy_strobe_n = 1'b1, vfy_ale = 1'b0, vfy_bank_sel = 1'b0, vfy_out_en_n = 1'b1;
  logic [1:0]  vfy_key = 2'b11;
  logic [11:0] vfy_addr = '0;
  logic [7:0]  vfy_data;
  logic        vfy_oe;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  codelock_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .lock_prog(lock_prog), .rst_pin(rst_pin), .ea_pin(ea_pin),
    .prog_en(prog_en), .ext_exec_en(ext_exec_en), .ea_eff(ea_eff),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_from_ext(req_from_ext), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_denied(rsp_denied), .vfy_strobe_n(vfy_strobe_n),
    .vfy_ale(vfy_ale), .vfy_bank_sel(vfy_bank_sel), .vfy_out_en_n(vfy_out_en_n),
    .vfy_key(vfy_key), .vfy_addr(vfy_addr), .vfy_data(vfy_data), .vfy_oe(vfy_oe)
  );

  function automatic logic [7:0] exp_code(input logic [11:0] a);
    return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'hA5;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic movc(input logic [11:0] a, input logic ext, input logic exp_den,
                      input logic [7:0] exp_dat, input string req);
    req_addr = a; req_from_ext = ext; req_valid = 1'b1;
    check({req, " ready"}, req_ready, 1'b1);
    step();
    req_valid = 1'b0;
    check({req, " valid"}, rsp_valid, 1'b1);
    check({req, " denied"}, rsp_denied, exp_den);
    check({req, " data"}, rsp_data, exp_dat);
    step();
  endtask

  task automatic vfy(input logic [1:0] key, input logic [11:0] a, input logic oe_n,
                     input logic exp_oe, input logic [7:0] exp_dat, input string req);
    rst_pin = 1'b1; ea_pin = 1'b1; vfy_strobe_n = 1'b0; vfy_ale = 1'b1;
    vfy_bank_sel = 1'b0; vfy_key = key; vfy_addr = a; vfy_out_en_n = oe_n;
    step();
    check({req, " oe"}, vfy_oe, exp_oe);
    check({req, " data"}, vfy_data, exp_dat);
  endtask

  task automatic vfy_idle();
    vfy_strobe_n = 1'b1; vfy_ale = 1'b0; vfy_out_en_n = 1'b1; rst_pin = 1'b0;
    step();
  endtask

  task automatic t_reset();
    repeat (3) step();
    rst_n = 1'b1;
    step();
    check("R1 rsp_valid", rsp_valid, 1'b0);
    check("R1 vfy_oe", vfy_oe, 1'b0);
    check("R1 vfy_data", vfy_data, 8'h00);
    check("R1 ea_eff before capture", ea_eff, 1'b0);
  endtask

  task automatic t_unlocked();
    lock_prog = 3'b000; step();
    check("R2 prog_en", prog_en, 1'b1);
    check("R2 ext_exec_en", ext_exec_en, 1'b1);
    ea_pin = 1'b0; #1 check("R2 ea live 0", ea_eff, 1'b0);
    ea_pin = 1'b1; #1 check("R2 ea live 1", ea_eff, 1'b1);
    step();
    movc(12'h123, 1'b1, 1'b0, exp_code(12'h123), "R2 movc ext");
    movc(12'hF0F, 1'b0, 1'b0, exp_code(12'hF0F), "R2 movc int");
  endtask

  task automatic t_lock1_movc();
    lock_prog = 3'b001; step();
    check("R3 prog_en", prog_en, 1'b0);
    movc(12'h456, 1'b1, 1'b1, 8'h00, "R3 movc ext denied");
    movc(12'h456, 1'b0, 1'b0, exp_code(12'h456), "R3 movc int granted");
  endtask

  task automatic t_strap();
    lock_prog = 3'b001;
    ea_pin = 1'b1; rst_pin = 1'b1; step(); step();
    rst_pin = 1'b0; step();
    ea_pin = 1'b0; step();
    check("R4 held 1", ea_eff, 1'b1);
    rst_pin = 1'b1; step();
    rst_pin = 1'b0; ea_pin = 1'b1; step();
    check("R4 held 0", ea_eff, 1'b0);
  endtask

  task automatic t_verify_code();
    lock_prog = 3'b000;
    vfy(2'b11, 12'h000, 1'b0, 1'b1, exp_code(12'h000), "R5 addr 000");
    vfy(2'b11, 12'hABC, 1'b0, 1'b1, exp_code(12'hABC), "R5 addr ABC");
    vfy(2'b11, 12'hFFF, 1'b0, 1'b1, exp_code(12'hFFF), "R5 addr FFF");
    vfy_idle();
  endtask

  task automatic t_verify_locked();
    lock_prog = 3'b001;
    vfy(2'b11, 12'h321, 1'b0, 1'b0, 8'h00, "R6 lb1");
    lock_prog = 3'b010;
    vfy(2'b11, 12'h321, 1'b0, 1'b0, 8'h00, "R6 lb2");
    vfy_idle();
  endtask

  task automatic t_signature();
    lock_prog = 3'b111;
    vfy(2'b00, 12'h030, 1'b0, 1'b1, 8'h1E, "R7 sig 030");
    vfy(2'b00, 12'h031, 1'b0, 1'b1, 8'h80, "R7 sig 031");
    lock_prog = 3'b000;
    vfy(2'b00, 12'h032, 1'b0, 1'b1, 8'h01, "R7 sig 032");
    vfy(2'b00, 12'h033, 1'b0, 1'b1, 8'hFF, "R7 sig other");
    vfy_idle();
  endtask

  task automatic t_verify_gating();
    lock_prog = 3'b000;
    vfy(2'b11, 12'h100, 1'b1, 1'b0, 8'h00, "R8 out_en_n high");
    vfy(2'b01, 12'h030, 1'b0, 1'b0, 8'h00, "R8 key 01");
    vfy_bank_sel = 1'b1; step();
    check("R8 bank_sel oe", vfy_oe, 1'b0);
    check("R8 bank_sel data", vfy_data, 8'h00);
    vfy_bank_sel = 1'b0; vfy_ale = 1'b0; step();
    check("R8 ale low oe", vfy_oe, 1'b0);
    vfy_idle();
  endtask

  task automatic t_lock_all();
    lock_prog = 3'b011; step();
    check("R9 two fuses ext_exec_en", ext_exec_en, 1'b1);
    lock_prog = 3'b111; step();
    check("R9 all fuses ext_exec_en", ext_exec_en, 1'b0);
    lock_prog = 3'b000; step();
  endtask

  task automatic t_backpressure();
    lock_prog = 3'b000; rsp_ready = 1'b0;
    req_addr = 12'h777; req_from_ext = 1'b0; req_valid = 1'b1;
    step();
    req_addr = 12'h778;
    check("R10 valid after accept", rsp_valid, 1'b1);
    check("R10 ready low when stalled", req_ready, 1'b0);
    step(); step();
    check("R10 held valid", rsp_valid, 1'b1);
    check("R10 held data", rsp_data, exp_code(12'h777));
    req_valid = 1'b0; rsp_ready = 1'b1;
    #1 check("R10 ready with drain", req_ready, 1'b1);
    step();
    check("R10 drained", rsp_valid, 1'b0);
  endtask

  task automatic t_rst_flush();
    rsp_ready = 1'b0;
    req_addr = 12'h055; req_valid = 1'b1; step();
    req_valid = 1'b0;
    check("R11 pending", rsp_valid, 1'b1);
    rst_pin = 1'b1;
    #1 check("R10 ready low in reset", req_ready, 1'b0);
    step();
    check("R11 flushed", rsp_valid, 1'b0);
    rst_pin = 1'b0; rsp_ready = 1'b1; step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_unlocked();
    t_lock1_movc();
    t_strap();
    t_verify_code();
    t_verify_locked();
    t_signature();
    t_verify_gating();
    t_lock_all();
    t_backpressure();
    t_rst_flush();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule